// File: doc/BRIEF.md
# Serial-Bus Register and RAM Command Engine

This block sits behind a byte-level serial-bus target front end. It turns the stream of bus events it receives (start, repeated start, stop, a received byte, and a request for a byte to send) into accesses on a register bus and on a RAM port. Each write transfer opens with a setup of three bytes: a command opcode, then the high half and then the low half of a 16-bit address. The bytes that follow the setup are data. Read-type commands return data in a later read phase. A repeated start usually opens that phase. A fresh transfer after a stop can open it too.

The setup outlives a stop. The stored command and the address counter stay in place, so a separate read transfer carries on from where the last access stopped. Some commands pin the address to one location, such as a polled status register or a register driven as a waveform. Other commands step through memory one byte at a time. RAM occupies a fixed window of addresses. A read outside the window returns a marker byte and does not touch the RAM. A write outside the window is dropped.

Top module: `sbus_cmd_engine`

## Requirements
- R1: In a write transfer, the first received byte after a start or repeated start is the opcode, the second is address bits 15:8 and the third is address bits 7:0; none of these three bytes causes a register or RAM write.
- R2: Opcodes: 0x01 register poll, 0x02 register sequential read, 0x03 register single-address write, 0x04 register sequential write, 0x06 RAM sequential read, 0x08 RAM sequential write.
- R3: From the fourth received byte of a transfer onward, each byte under opcode 0x03, 0x04 or 0x08 is written with `reg_wdata`/`ram_wdata` equal to that byte; under 0x03 every byte goes to the same address.
- R4: Under 0x04 and 0x08 the address counter advances by one after each data byte, so consecutive bytes land at consecutive addresses.
- R5: Under 0x01 every returned byte is read from the one setup address; the counter does not move.
- R6: Under 0x02 and 0x06 each returned byte comes from the next higher address.
- R7: Command and address counter are kept across a stop; a later read transfer without a new setup continues from the stored command and the advanced address.
- R8: RAM occupies 0x0400 to 0x04FF inclusive. A 0x06 read outside it returns 0xDE with no `ram_re`, and the counter still advances.
- R9: A 0x08 data byte addressed outside the RAM window raises no `ram_we`, and the counter still advances.
- R10: A stored opcode that is not one of the six makes the engine ignore the rest of that transfer: no address load and no access. A read request returns 0xFF and makes no access when the stored opcode is unknown or is a write-type opcode.
- R11: A read request raises `reg_re` or `ram_re` in the same cycle. `tx_valid` is high in the next cycle only, with `tx_byte` holding the byte.
- R12: After reset no strobe is active, `tx_valid` is low, and the stored command counts as unknown, so reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start condition seen |
| bus_rstart | input | 1 | Repeated start seen |
| bus_stop | input | 1 | Stop condition seen |
| rx_valid | input | 1 | A byte written by the host is available |
| rx_byte | input | DATA_W | Received byte |
| tx_req | input | 1 | Front end needs a byte to send |
| tx_valid | output | 1 | Returned byte valid (one cycle after tx_req) |
| tx_byte | output | DATA_W | Byte to send |
| reg_addr | output | ADDR_W | Register bus address |
| reg_wdata | output | DATA_W | Register write data |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read strobe |
| reg_rdata | input | DATA_W | Register read data, one cycle after reg_re |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | DATA_W | RAM read data, one cycle after ram_re |

## Verification
The hardest state to reach is a read transfer that runs on a setup made in an earlier, already-stopped transfer, after that setup's address counter has already moved. The bench reaches it in stages. It writes a run of registers, reads part of the run back behind a repeated start, closes with a stop, and then opens a bare read transfer, which must pick up at the next address. The same approach drives a RAM write and a RAM read across the top edge of the window, so the marker byte and the dropped write show up at the exact byte where the counter crosses 0x04FF.

// File: rtl/sbus_cmd_pkg.sv
package sbus_cmd_pkg;

  localparam logic [7:0] OP_NONE  = 8'h00;
  localparam logic [7:0] OP_POLL  = 8'h01;
  localparam logic [7:0] OP_RDSEQ = 8'h02;
  localparam logic [7:0] OP_SET   = 8'h03;
  localparam logic [7:0] OP_WRSEQ = 8'h04;
  localparam logic [7:0] OP_RAMRD = 8'h06;
  localparam logic [7:0] OP_RAMWR = 8'h08;

  typedef enum logic [1:0] {PH_CMD, PH_AHI, PH_ALO, PH_DATA} phase_e;
  typedef enum logic [1:0] {SRC_EMPTY, SRC_REG, SRC_RAM, SRC_MARK} rsrc_e;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_POLL) || (op == OP_RDSEQ) || (op == OP_SET) ||
           (op == OP_WRSEQ) || (op == OP_RAMRD) || (op == OP_RAMWR);
  endfunction

  function automatic logic op_steps(input logic [7:0] op);
    return (op == OP_RDSEQ) || (op == OP_WRSEQ) || (op == OP_RAMRD) || (op == OP_RAMWR);
  endfunction

  function automatic logic op_writes_reg(input logic [7:0] op);
    return (op == OP_SET) || (op == OP_WRSEQ);
  endfunction

  function automatic logic op_reads_reg(input logic [7:0] op);
    return (op == OP_POLL) || (op == OP_RDSEQ);
  endfunction

endpackage

// File: rtl/sce_setup.sv
module sce_setup
  import sbus_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_begin,
  input  logic              xfer_end,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              adv,
  output logic [7:0]        cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              data_stb
);

  phase_e phase_q;
  logic   active_q;
  logic   byte_in;

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  assign byte_in  = rx_valid && active_q && !xfer_begin && !xfer_end;
  assign data_stb = byte_in && (phase_q == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_CMD;
      cmd_q    <= OP_NONE;
      addr_q   <= '0;
    end else begin
      if (xfer_begin) begin
        active_q <= 1'b1;
        phase_q  <= PH_CMD;
      end else if (xfer_end) begin
        active_q <= 1'b0;
      end else if (byte_in) begin
        case (phase_q)
          PH_CMD: begin
            cmd_q   <= rx_byte[7:0];
            phase_q <= PH_AHI;
          end
          PH_AHI: begin
            if (op_known(cmd_q)) addr_q[ADDR_W-1 -: DATA_W] <= rx_byte;
            phase_q <= PH_ALO;
          end
          PH_ALO: begin
            if (op_known(cmd_q)) addr_q[DATA_W-1:0] <= rx_byte;
            phase_q <= PH_DATA;
          end
          default: phase_q <= PH_DATA;
        endcase
      end
      if (adv) addr_q <= addr_next(addr_q);
    end
  end

  // R4 / R6: each advance moves the counter by exactly one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1)));

  // R7: a stop leaves command and address untouched
  p_keep_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> ($stable(cmd_q) && $stable(addr_q)));

endmodule

// File: rtl/sce_access.sv
module sce_access
  import sbus_cmd_pkg::*;
#(
  parameter int                 DATA_W = 8,
  parameter int                 ADDR_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0]  WIN_LO = 'h0400,
  parameter logic [ADDR_W-1:0]  WIN_HI = 'h04FF,
  parameter logic [DATA_W-1:0]  MARK   = 'hDE,
  parameter logic [DATA_W-1:0]  EMPTY  = 'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cmd_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              data_stb,
  input  logic              tx_req,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              reg_we,
  output logic              reg_re,
  output logic              ram_we,
  output logic              ram_re,
  output logic              adv,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_byte
);

  rsrc_e src_d, src_q;
  logic  in_win;

  function automatic logic win_hit(input logic [ADDR_W-1:0] a);
    return (a >= WIN_LO) && (a <= WIN_HI);
  endfunction

  assign in_win = win_hit(addr_q);
  assign reg_we = data_stb && op_writes_reg(cmd_q);
  assign ram_we = data_stb && (cmd_q == OP_RAMWR) && in_win;
  assign reg_re = tx_req && op_reads_reg(cmd_q);
  assign ram_re = tx_req && (cmd_q == OP_RAMRD) && in_win;
  assign adv    = op_steps(cmd_q) && (data_stb || tx_req) &&
                  ((cmd_q == OP_WRSEQ || cmd_q == OP_RAMWR) ? data_stb : tx_req);

  always_comb begin
    src_d = SRC_EMPTY;
    if (reg_re)                               src_d = SRC_REG;
    else if (ram_re)                          src_d = SRC_RAM;
    else if (tx_req && cmd_q == OP_RAMRD)     src_d = SRC_MARK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      src_q    <= SRC_EMPTY;
    end else begin
      tx_valid <= tx_req;
      src_q    <= src_d;
    end
  end

  always_comb begin
    case (src_q)
      SRC_REG:  tx_byte = reg_rdata;
      SRC_RAM:  tx_byte = ram_rdata;
      SRC_MARK: tx_byte = MARK;
      default:  tx_byte = EMPTY;
    endcase
  end

  // R11: every request is answered in the following cycle
  p_answer_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> tx_valid);

  // R5: polling never moves the counter
  p_poll_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && cmd_q == OP_POLL) |-> !adv);

  // R10: an unknown command makes no access at all
  p_bad_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_known(cmd_q) |-> !(reg_we || ram_we || reg_re || ram_re));

  // R8: an out-of-window RAM read answers with the marker
  p_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && cmd_q == OP_RAMRD && !in_win) |=> (tx_valid && tx_byte == MARK));

endmodule

// File: rtl/sbus_cmd_engine.sv
module sbus_cmd_engine
  import sbus_cmd_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter int                ADDR_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] WIN_LO = 'h0400,
  parameter logic [ADDR_W-1:0] WIN_HI = 'h04FF,
  parameter logic [DATA_W-1:0] MARK   = 'hDE,
  parameter logic [DATA_W-1:0] EMPTY  = 'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_rstart,
  input  logic              bus_stop,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_byte,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  input  logic [DATA_W-1:0] ram_rdata
);

  logic [7:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              data_stb;
  logic              adv;
  logic              xfer_begin;

  assign xfer_begin = bus_start || bus_rstart;

  sce_setup #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_setup (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_begin (xfer_begin),
    .xfer_end   (bus_stop),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .adv        (adv),
    .cmd_q      (cmd_q),
    .addr_q     (addr_q),
    .data_stb   (data_stb)
  );

  sce_access #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .MARK(MARK), .EMPTY(EMPTY)
  ) u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_q     (cmd_q),
    .addr_q    (addr_q),
    .data_stb  (data_stb),
    .tx_req    (tx_req),
    .reg_rdata (reg_rdata),
    .ram_rdata (ram_rdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .adv       (adv),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  assign reg_addr  = addr_q;
  assign ram_addr  = addr_q;
  assign reg_wdata = rx_byte;
  assign ram_wdata = rx_byte;

  // R1: setup bytes never write anywhere
  p_setup_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !data_stb) |-> !(reg_we || ram_we));

  // R9: the RAM write strobe only fires inside the window
  p_ram_wr_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr >= WIN_LO && ram_addr <= WIN_HI));

endmodule

// File: tb/test_sbus_cmd_engine.sv
module test_sbus_cmd_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 0, bus_rstart = 0, bus_stop = 0;
  logic        rx_valid = 0, tx_req = 0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic [15:0] reg_addr, ram_addr;
  logic [7:0]  reg_wdata, ram_wdata, reg_rdata, ram_rdata;
  logic        reg_we, reg_re, ram_we, ram_re;

  always #2.5 clk = ~clk;

  sbus_cmd_engine i_sbus_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rstart(bus_rstart),
    .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_rdata(ram_rdata)
  );

  // memory models driven by the design's strobes
  logic [7:0] mreg [256];
  logic [7:0] mram [256];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        mreg[i] <= 8'(i) ^ 8'h3C;
        mram[i] <= 8'(i * 7 + 1);
      end
      reg_rdata <= '0;
      ram_rdata <= '0;
    end else begin
      if (reg_we) mreg[reg_addr[7:0]] <= reg_wdata;
      if (ram_we) mram[ram_addr[7:0]] <= ram_wdata;
      if (reg_re) reg_rdata <= mreg[reg_addr[7:0]];
      if (ram_re) ram_rdata <= mram[ram_addr[7:0]];
    end
  end

  // bench-side prediction of memory contents
  logic [7:0] sreg [256];
  logic [7:0] sram [256];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0]  rexp[$];
  string       rtag[$];
  logic [24:0] wexp[$];
  string       wtag[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expectations as the design produces results
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        if (rexp.size() == 0) check(0, "R11 unexpected tx_valid", {24'd0, tx_byte}, 32'd0);
        else begin
          automatic logic [7:0] e = rexp.pop_front();
          automatic string t = rtag.pop_front();
          check(tx_byte == e, t, {24'd0, tx_byte}, {24'd0, e});
        end
      end
      if (reg_we || ram_we) begin
        automatic logic [24:0] got = {ram_we, (ram_we ? ram_addr : reg_addr), (ram_we ? ram_wdata : reg_wdata)};
        if (wexp.size() == 0) check(0, "R1/R10 unexpected write", {7'd0, got}, 32'd0);
        else begin
          automatic logic [24:0] e = wexp.pop_front();
          automatic string t = wtag.pop_front();
          check(got == e, t, {7'd0, got}, {7'd0, e});
        end
      end
      if (ram_re && (ram_addr < 16'h0400 || ram_addr > 16'h04FF))
        check(0, "R8 ram_re outside window", {16'd0, ram_addr}, 32'd0);
      if (ram_we && (ram_addr < 16'h0400 || ram_addr > 16'h04FF))
        check(0, "R9 ram_we outside window", {16'd0, ram_addr}, 32'd0);
    end
  end

  localparam int E_START = 0, E_RSTART = 1, E_STOP = 2, E_BYTE = 3, E_READ = 4;

  task automatic ev(input int sel, input logic [7:0] b);
    @(posedge clk); #1;
    case (sel)
      E_START:  bus_start = 1;
      E_RSTART: bus_rstart = 1;
      E_STOP:   bus_stop = 1;
      E_BYTE:   begin rx_valid = 1; rx_byte = b; end
      default:  tx_req = 1;
    endcase
    if (sel == E_READ) begin
      @(negedge clk);
      check(!tx_valid, "R11 tx_valid early", {31'd0, tx_valid}, 32'd0);
    end
    @(posedge clk); #1;
    bus_start = 0; bus_rstart = 0; bus_stop = 0; rx_valid = 0; tx_req = 0;
  endtask

  task automatic setup(input logic [7:0] op, input logic [15:0] a);
    ev(E_BYTE, op); ev(E_BYTE, a[15:8]); ev(E_BYTE, a[7:0]);
  endtask

  task automatic wr_data(input logic [7:0] b, input bit ram, input logic [15:0] a, input bit hit, input string t);
    if (hit) begin
      wexp.push_back({ram, a, b});
      wtag.push_back(t);
      if (ram) sram[a[7:0]] = b; else sreg[a[7:0]] = b;
    end
    ev(E_BYTE, b);
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    rexp.push_back(e);
    rtag.push_back(t);
    ev(E_READ, 8'h00);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      sreg[i] = 8'(i) ^ 8'h3C;
      sram[i] = 8'(i * 7 + 1);
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!tx_valid && !reg_we && !ram_we && !reg_re && !ram_re, "R12 reset outputs",
          {27'd0, tx_valid, reg_we, ram_we, reg_re, ram_re}, 32'd0);

    // R12: no setup yet -> empty byte
    ev(E_START, 0); rd(8'hFF, "R12 read before setup"); ev(E_STOP, 0);

    // R1 R3 R4: sequential register write
    ev(E_START, 0); setup(8'h04, 16'h0010);
    wr_data(8'hAA, 0, 16'h0010, 1, "R4 wrseq b0");
    wr_data(8'hBB, 0, 16'h0011, 1, "R4 wrseq b1");
    wr_data(8'hCC, 0, 16'h0012, 1, "R3 wrseq b2");
    ev(E_STOP, 0);

    // R6: sequential register read behind repeated start
    ev(E_START, 0); setup(8'h02, 16'h0010); ev(E_RSTART, 0);
    rd(sreg[8'h10], "R6 rdseq 0010"); rd(sreg[8'h11], "R6 rdseq 0011"); rd(sreg[8'h12], "R6 rdseq 0012");
    ev(E_STOP, 0);

    // R7: fresh read transfer resumes at 0x0013
    ev(E_START, 0); rd(sreg[8'h13], "R7 resume 0013"); rd(sreg[8'h14], "R7 resume 0014"); ev(E_STOP, 0);

    // R2 R3: single-address write
    ev(E_START, 0); setup(8'h03, 16'h0020);
    wr_data(8'h01, 0, 16'h0020, 1, "R3 set b0");
    wr_data(8'h02, 0, 16'h0020, 1, "R3 set b1");
    wr_data(8'h03, 0, 16'h0020, 1, "R3 set b2");
    ev(E_STOP, 0);

    // R5 R7: poll setup, stop, separate read transfer
    ev(E_START, 0); setup(8'h01, 16'h0020); ev(E_STOP, 0);
    ev(E_START, 0);
    rd(sreg[8'h20], "R5 poll 0"); rd(sreg[8'h20], "R5 poll 1"); rd(sreg[8'h20], "R5 poll 2");
    ev(E_STOP, 0);

    // R9: RAM write crossing the window top
    ev(E_START, 0); setup(8'h08, 16'h04FE);
    wr_data(8'h11, 1, 16'h04FE, 1, "R4 ramwr 04FE");
    wr_data(8'h22, 1, 16'h04FF, 1, "R4 ramwr 04FF");
    wr_data(8'h33, 1, 16'h0500, 0, "R9 ramwr 0500");
    ev(E_STOP, 0);

    // R8: RAM read crossing the window top
    ev(E_START, 0); setup(8'h06, 16'h04FD); ev(E_RSTART, 0);
    rd(sram[8'hFD], "R6 ramrd 04FD"); rd(sram[8'hFE], "R8 ramrd 04FE");
    rd(sram[8'hFF], "R8 ramrd 04FF"); rd(8'hDE, "R8 ramrd 0500 marker");
    ev(E_STOP, 0);

    // R8: RAM read from below the window
    ev(E_START, 0); setup(8'h06, 16'h03FF); ev(E_RSTART, 0);
    rd(8'hDE, "R8 ramrd 03FF marker"); rd(sram[8'h00], "R8 ramrd 0400");
    ev(E_STOP, 0);

    // R10: unknown opcode ignored, reads empty
    ev(E_START, 0); setup(8'h05, 16'h0010);
    wr_data(8'h55, 0, 16'h0010, 0, "R10 bad data");
    ev(E_RSTART, 0); rd(8'hFF, "R10 bad cmd read"); ev(E_STOP, 0);

    // R10: read with a write-type command stored
    ev(E_START, 0); setup(8'h04, 16'h0030); ev(E_RSTART, 0);
    rd(8'hFF, "R10 write cmd read"); ev(E_STOP, 0);

    // R1: recovery with a valid setup after the bad one
    ev(E_START, 0); setup(8'h02, 16'h0010); ev(E_RSTART, 0);
    rd(sreg[8'h10], "R1 reparse after bad"); ev(E_STOP, 0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rexp.size() == 0 && wexp.size() == 0, "R11 all expectations consumed",
          32'(rexp.size()), 32'(wexp.size()));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule